// File: doc/BRIEF.md
# Byte-Wide Parallel Configuration Port

This block is the slave side of a byte-wide configuration interface. A host loads configuration bytes over an 8-bit bus under an active-low chip select and an active-low write strobe, all sampled on the rising edge of the configuration clock. Each accepted byte is bit-reversed into conventional order and handed to the internal consumer as a one-cycle stream beat. With the write strobe released and chip select held, the host reads bytes back: the block takes them from an internal source and drives them onto the bus, again in the bus's reversed bit order.

A load begins with the first accepted write and ends when the downstream consumer signals completion. If the write strobe rises while a load is still open, the load is abandoned, an abort flag is raised, and the port refuses writes until the host shows a clean idle cycle with both controls high. The port answers only when the mode pins select one of the two byte-parallel configuration modes.

Top module: `cfg_parallel_port`

## Requirements
- R1: A byte is accepted at a rising clock edge where `cs_n`=0, `wr_n`=0, the mode is parallel and the port is not aborted; `strm_valid` is high for exactly the cycle after that edge.
- R2: Bus bit 0 is the most significant bit: `strm_data[7-i]` equals `bus_in[i]` of the accepted byte, so `bus_in`=8'h3F yields `strm_data`=8'hFC.
- R3: At an edge with `cs_n`=1 no byte is accepted, no readback byte is taken, and `bus_oe` is low in the following cycle.
- R4: The port acts only when `cfg_mode` (M2,M1,M0 from bit 2 down) is 3'b011 or 3'b110; with any other value writes and readback are ignored.
- R5: If `wr_n`=1 at an edge while a load is open and `load_done`=0, the load is abandoned and `abort_flag` is high from the next cycle.
- R6: While `abort_flag` is high, writes are ignored; an edge with `cs_n`=1 and `wr_n`=1 clears `abort_flag` for the next cycle, after which writes are accepted again.
- R7: A readback byte is taken at an edge where `cs_n`=0, `wr_n`=1, the mode is parallel, no load is open and the port is not aborted; `rb_take` is high combinationally before that edge, and in the next cycle `bus_oe`=1 and `bus_out[i]`=`rb_data[7-i]`.
- R8: `load_done` high at an edge closes the open load, so a later rise of `wr_n` does not abort.
- R9: `cs_n` and `wr_n` may fall in either order; the first edge where both are low accepts the byte.
- R10: After reset `strm_valid`, `bus_oe`, `abort_flag` and `bus_out` are 0 and `bus_oe` stays 0 until the cycle after the first readback edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 3 | Mode pins M2..M0 |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write (high = read) |
| bus_in | input | 8 | Data bus input, bit 0 = MSB |
| bus_out | output | 8 | Data bus output, bit 0 = MSB |
| bus_oe | output | 1 | Data bus output enable |
| rb_data | input | 8 | Readback byte source, bit 7 = MSB |
| rb_take | output | 1 | Readback byte consumed at this edge |
| strm_data | output | 8 | Accepted byte, bit 7 = MSB |
| strm_valid | output | 1 | One-cycle valid for `strm_data` |
| load_done | input | 1 | Downstream signals end of load |
| abort_flag | output | 1 | Load abandoned, waiting for idle |

## Verification
The assertions assume every input is settled before each rising edge and that `load_done` comes only from a consumer that has seen at least one byte, though a stray pulse is harmless. The stimulus changes inputs only on the falling edge, draws modes mostly from the two parallel codes with occasional invalid ones, and biases the controls so that loads, aborts, recoveries and readback bursts all occur many times in the random phase.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
    localparam logic [2:0] MODE_MASTER_PAR = 3'b011;
    localparam logic [2:0] MODE_SLAVE_PAR  = 3'b110;

    typedef struct packed {
        logic active;
        logic locked;
    } cfgp_ctl_t;
endpackage

// File: rtl/cfgp_write_path.sv
module cfgp_write_path
    import cfgp_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_ok,
    input  logic             cs_n,
    input  logic             wr_n,
    input  logic [BUS_W-1:0] bus_in,
    input  logic             load_done,
    output logic [BUS_W-1:0] strm_data,
    output logic             strm_valid,
    output cfgp_ctl_t        ctl
);
    typedef struct packed {
        cfgp_ctl_t        ctl;
        logic [BUS_W-1:0] data;
        logic             valid;
    } wr_state_t;

    wr_state_t        st_d, st_q;
    logic [BUS_W-1:0] rev_in;
    logic             accept;
    logic             abort_evt;

    for (genvar i = 0; i < BUS_W; i++) begin : g_rev
        assign rev_in[BUS_W-1-i] = bus_in[i];
    end

    always_comb begin
        st_d      = st_q;
        accept    = mode_ok && !cs_n && !wr_n && !st_q.ctl.locked;
        abort_evt = st_q.ctl.active && wr_n && !load_done;
        st_d.valid = accept;
        if (accept) begin
            st_d.data = rev_in;
        end
        if (load_done || abort_evt) begin
            st_d.ctl.active = 1'b0;
        end else if (accept) begin
            st_d.ctl.active = 1'b1;
        end
        if (abort_evt) begin
            st_d.ctl.locked = 1'b1;
        end else if (st_q.ctl.locked && cs_n && wr_n) begin
            st_d.ctl.locked = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign strm_data  = st_q.data;
    assign strm_valid = st_q.valid;
    assign ctl        = st_q.ctl;

    assert_write_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ok && !cs_n && !wr_n && !ctl.locked) |=> strm_valid);
    assert_bit_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ok && !cs_n && !wr_n && !ctl.locked) |=> (strm_data[BUS_W-1] == $past(bus_in[0])));
    assert_chip_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !strm_valid);
    assert_abort_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.active && wr_n && !load_done) |=> ctl.locked);
    assert_locked_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.locked |=> !strm_valid);
    assert_done_close_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> !ctl.active);
endmodule

// File: rtl/cfgp_read_path.sv
module cfgp_read_path
    import cfgp_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_ok,
    input  logic             cs_n,
    input  logic             wr_n,
    input  cfgp_ctl_t        ctl,
    input  logic [BUS_W-1:0] rb_data,
    output logic             rb_take,
    output logic [BUS_W-1:0] bus_out,
    output logic             bus_oe
);
    typedef struct packed {
        logic [BUS_W-1:0] out;
        logic             oe;
    } rd_state_t;

    rd_state_t        st_d, st_q;
    logic [BUS_W-1:0] rev_rb;
    logic             rb_cond;

    for (genvar i = 0; i < BUS_W; i++) begin : g_rev
        assign rev_rb[BUS_W-1-i] = rb_data[i];
    end

    always_comb begin
        st_d    = st_q;
        rb_cond = mode_ok && !cs_n && wr_n && !ctl.active && !ctl.locked;
        st_d.oe = rb_cond;
        if (rb_cond) begin
            st_d.out = rev_rb;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rb_take = rb_cond;
    assign bus_out = st_q.out;
    assign bus_oe  = st_q.oe;

    assert_oe_off_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !bus_oe);
    assert_readback_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rb_take |=> (bus_oe && bus_out[0] == $past(rb_data[BUS_W-1])));
    assert_no_read_while_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.locked |-> !rb_take);
endmodule

// File: rtl/cfg_parallel_port.sv
module cfg_parallel_port
    import cfgp_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cfg_mode,
    input  logic             cs_n,
    input  logic             wr_n,
    input  logic [BUS_W-1:0] bus_in,
    output logic [BUS_W-1:0] bus_out,
    output logic             bus_oe,
    input  logic [BUS_W-1:0] rb_data,
    output logic             rb_take,
    output logic [BUS_W-1:0] strm_data,
    output logic             strm_valid,
    input  logic             load_done,
    output logic             abort_flag
);
    logic      mode_ok;
    cfgp_ctl_t ctl;

    assign mode_ok = (cfg_mode == MODE_MASTER_PAR) || (cfg_mode == MODE_SLAVE_PAR);

    cfgp_write_path #(.BUS_W(BUS_W)) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_ok    (mode_ok),
        .cs_n       (cs_n),
        .wr_n       (wr_n),
        .bus_in     (bus_in),
        .load_done  (load_done),
        .strm_data  (strm_data),
        .strm_valid (strm_valid),
        .ctl        (ctl)
    );

    cfgp_read_path #(.BUS_W(BUS_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_ok (mode_ok),
        .cs_n    (cs_n),
        .wr_n    (wr_n),
        .ctl     (ctl),
        .rb_data (rb_data),
        .rb_take (rb_take),
        .bus_out (bus_out),
        .bus_oe  (bus_oe)
    );

    assign abort_flag = ctl.locked;

    assert_mode_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_ok |=> (!strm_valid && !bus_oe));
    assert_one_direction_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({strm_valid, bus_oe}));
endmodule

// File: tb/cfg_parallel_port_tb_top.sv
module cfg_parallel_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_mode = 3'b110;
    logic       cs_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [7:0] bus_in = '0;
    logic [7:0] bus_out;
    logic       bus_oe;
    logic [7:0] rb_data = '0;
    logic       rb_take;
    logic [7:0] strm_data;
    logic       strm_valid;
    logic       load_done = 1'b0;
    logic       abort_flag;

    int n_checks = 0;
    int n_fail   = 0;

    bit         m_active = 0, m_locked = 0;
    logic [7:0] e_data = '0, e_out = '0;
    bit         e_valid = 0, e_oe = 0;
    logic [7:0] rb_cnt = 8'h5A;

    always #4 clk = ~clk;

    cfg_parallel_port dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cs_n(cs_n), .wr_n(wr_n),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .rb_data(rb_data),
        .rb_take(rb_take), .strm_data(strm_data), .strm_valid(strm_valid),
        .load_done(load_done), .abort_flag(abort_flag)
    );

    function automatic logic [7:0] rev8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[7-i] = v[i];
        return r;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive at the falling edge, let the rising edge capture, compare at the next falling edge.
    task automatic cyc(input bit cs, input bit wr, input logic [2:0] md,
                       input logic [7:0] din, input bit done);
        bit mok, acc, ab, rb;
        cs_n = cs; wr_n = wr; cfg_mode = md; bus_in = din; load_done = done;
        rb_data = rb_cnt;
        #1;
        mok = (md == 3'b011) || (md == 3'b110);
        acc = mok && !cs && !wr && !m_locked;
        ab  = m_active && wr && !done;
        rb  = mok && !cs && wr && !m_active && !m_locked;
        check("R7 rb_take", {7'd0, rb_take}, {7'd0, rb});
        e_valid = acc;
        if (acc) e_data = rev8(din);
        e_oe = rb;
        if (rb) begin
            e_out = rev8(rb_cnt);
            rb_cnt = rb_cnt + 8'd37;
        end
        if (done || ab) m_active = 0;
        else if (acc)   m_active = 1;
        if (ab) m_locked = 1;
        else if (m_locked && cs && wr) m_locked = 0;
        @(negedge clk);
        check("R1 strm_valid", {7'd0, strm_valid}, {7'd0, e_valid});
        check("R2 strm_data", strm_data, e_data);
        check("R3 bus_oe", {7'd0, bus_oe}, {7'd0, e_oe});
        check("R7 bus_out", bus_out, e_out);
        check("R5 abort_flag", {7'd0, abort_flag}, {7'd0, m_locked});
    endtask

    initial begin
        #(8 * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_ABCD));
        #20;
        // R10 reset state
        check("R10 strm_valid", {7'd0, strm_valid}, 8'd0);
        check("R10 bus_oe", {7'd0, bus_oe}, 8'd0);
        check("R10 abort_flag", {7'd0, abort_flag}, 8'd0);
        check("R10 bus_out", bus_out, 8'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: 0xFC example, bus bits 0..5 set
        cyc(0, 0, 3'b110, 8'h3F, 0);
        check("R2 fc byte", strm_data, 8'hFC);
        cyc(1, 0, 3'b110, 8'h00, 0);
        check("R1 pulse one cycle", {7'd0, strm_valid}, 8'd0);
        cyc(1, 0, 3'b110, 8'h00, 1);      // R8 close the load
        cyc(1, 1, 3'b110, 8'h00, 0);
        check("R8 no abort after done", {7'd0, abort_flag}, 8'd0);

        // R9: wr_n first, then cs_n
        cyc(1, 0, 3'b011, 8'h81, 0);
        check("R9 wr first no accept", {7'd0, strm_valid}, 8'd0);
        cyc(0, 0, 3'b011, 8'h81, 0);
        check("R9 accepted", strm_data, 8'h81);
        cyc(1, 0, 3'b011, 8'h00, 1);
        cyc(1, 1, 3'b011, 8'h00, 0);

        // R4: invalid mode ignored
        cyc(0, 0, 3'b000, 8'h55, 0);
        check("R4 write ignored", {7'd0, strm_valid}, 8'd0);
        cyc(0, 1, 3'b101, 8'h00, 0);
        check("R4 read ignored", {7'd0, bus_oe}, 8'd0);

        // R5/R6: abort, locked writes, recovery
        cyc(1, 1, 3'b110, 8'h00, 0);
        cyc(0, 0, 3'b110, 8'h12, 0);
        cyc(0, 1, 3'b110, 8'h00, 0);
        check("R5 abort raised", {7'd0, abort_flag}, 8'd1);
        cyc(0, 0, 3'b110, 8'h77, 0);
        check("R6 write ignored", {7'd0, strm_valid}, 8'd0);
        cyc(1, 1, 3'b110, 8'h00, 0);
        check("R6 abort cleared", {7'd0, abort_flag}, 8'd0);
        cyc(0, 0, 3'b110, 8'hC3, 0);
        check("R6 write after recovery", strm_data, 8'hC3);
        cyc(1, 0, 3'b110, 8'h00, 1);

        // R7 readback burst then R3 chip select release
        cyc(1, 1, 3'b110, 8'h00, 0);
        check("R10 oe before readback", {7'd0, bus_oe}, 8'd0);
        for (int k = 0; k < 4; k++) cyc(0, 1, 3'b110, 8'h00, 0);
        check("R7 oe on", {7'd0, bus_oe}, 8'd1);
        cyc(1, 1, 3'b110, 8'hFF, 0);
        check("R3 oe off", {7'd0, bus_oe}, 8'd0);

        // random phase
        for (int n = 0; n < 3000; n++) begin
            bit cs, wr, dn;
            logic [2:0] md;
            cs = ($urandom % 4) == 0;
            wr = ($urandom % 3) == 0;
            dn = ($urandom % 12) == 0;
            md = (($urandom % 8) == 0) ? 3'($urandom) : ((($urandom % 2) == 0) ? 3'b110 : 3'b011);
            cyc(cs, wr, md, 8'($urandom), dn);
        end

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule